// File: doc/BRIEF.md
# Pattern Error Insertion Controller

This block sits on the serial transmit path of a bit-error-rate test pattern generator. It inverts chosen bits of the outgoing pattern so that the error detector at the far end can be checked. The pattern bit and its strobe pass through the block with no delay. The bit comes out inverted only when an error is due.

The block has two independent ways to insert errors. In rate mode, a 3-bit field sets a decade exponent n, and one bit in every 10^n strobed bits is inverted. In single mode, which has its own enable, each request inverts exactly one later bit. A request is either a one-cycle software strobe or a rising edge on an asynchronous manual pin. A saturating counter records how many bits were inverted. This counter can be removed by a parameter.

Top module: `err_inject_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `bit_out` equals `bit_in` and `err_cnt` is 0.
- R2: A rate field of 0 turns rate insertion off. With single mode disabled, `bit_out` always equals `bit_in`.
- R3: A rate field value v from 1 to 7 gives the exponent n = min(v, MAX_EXP). Counting strobed bits from a restart, the 10^n-th, 2·10^n-th and every later multiple is inverted.
- R4: Only cycles with `bit_vld` high advance the rate count. When `bit_vld` is low, `bit_out` equals `bit_in`.
- R5: Any change of the rate field restarts the count. A strobed bit in the cycle where the field changes is not counted and is never inverted by rate mode.
- R6: With `single_en` high, a one-cycle `sw_strobe` arms a pending error. The first strobed bit in a later cycle is inverted, and only that one.
- R7: `pin_req` passes through SYNC_STAGES flip-flops and is edge-detected. Each low-to-high transition gives exactly one inverted bit, however long the pin stays high.
- R8: With `single_en` low, software and pin requests are ignored, any pending error is dropped, and no single-mode inversion occurs.
- R9: If a rate error and a pending single error fall on the same strobed bit, that bit is inverted once and the pending error is consumed.
- R10: `err_cnt` rises by one for each inverted bit and stays at its all-ones value once it reaches it.
- R11: A pending error survives cycles with `bit_vld` low. Several requests made before it is consumed merge into one inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Pattern bit from the generator |
| bit_vld | input | 1 | High when `bit_in` is a transmitted bit |
| rate_sel | input | 3 | Decade exponent for rate mode, 0 = off |
| single_en | input | 1 | Enables single-error requests |
| sw_strobe | input | 1 | One-cycle single-error request from a register write |
| pin_req | input | 1 | Asynchronous manual error-request pin |
| bit_out | output | 1 | Pattern bit after insertion (combinational from `bit_in`) |
| err_cnt | output | ERR_CNT_W | Saturating count of inverted bits, 0 when COUNT_EN = 0 |

## Verification
The bench builds the block with MAX_EXP = 4, SYNC_STAGES = 3 and ERR_CNT_W = 6. The smaller exponent ceiling makes the clamp of field values 5 to 7 cheap to reach: a full 10^4-bit period is run with field 6. Three synchronizer stages exercise the pin path beyond its minimum depth. A 6-bit counter can be driven into saturation within a few hundred strobed bits at n = 1, so the hold at all-ones is observed. Gapped strobes, restarts in mid-period, coinciding rate and single errors, and disabled requests are each compared bit by bit against an independent model.

// File: rtl/eic_pkg.sv
package eic_pkg;

   localparam int EIC_RATE_W = 3;
   localparam int EIC_RATE_N = 1 << EIC_RATE_W;

   // field value that disables rate-based insertion
   localparam logic [EIC_RATE_W-1:0] EIC_RATE_OFF = '0;

   // sources of a single-error request
   typedef struct packed {
      logic sw;
      logic pin;
   } eic_req_t;

   function automatic longint unsigned eic_pow10(input int unsigned e);
      longint unsigned p = 1;
      for (int unsigned i = 0; i < e; i++) p = p * 10;
      return p;
   endfunction

endpackage

// File: rtl/eic_pin_sync.sv
module eic_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o
);

   logic [STAGES-1:0] sh_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         last_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], pin_i};
         last_q <= sh_q[STAGES-1];
      end
   end

   assign rise_o = sh_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/eic_decade_rate.sv
module eic_decade_rate
   import eic_pkg::*;
#(
   parameter int MAX_EXP = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [EIC_RATE_W-1:0] rate_sel,
   input  logic                  bit_vld,
   output logic                  hit_o
);

   localparam int CNT_W = $clog2(eic_pow10(MAX_EXP));

   logic [CNT_W-1:0]      lim_tab [EIC_RATE_N];
   logic [CNT_W-1:0]      cnt_q;
   logic [CNT_W-1:0]      lim;
   logic [EIC_RATE_W-1:0] rate_q;
   logic                  restart;
   logic                  active;

   // terminal count per field value; values above MAX_EXP use MAX_EXP
   for (genvar k = 0; k < EIC_RATE_N; k++) begin : g_lim
      localparam int unsigned EXP_K = (k <= MAX_EXP) ? k : MAX_EXP;
      assign lim_tab[k] = CNT_W'(eic_pow10(EXP_K) - 1);
   end

   assign lim     = lim_tab[rate_q];
   assign restart = (rate_sel != rate_q);
   assign active  = (rate_q != EIC_RATE_OFF);
   assign hit_o   = bit_vld && !restart && active && (cnt_q == lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= EIC_RATE_OFF;
         cnt_q  <= '0;
      end else begin
         rate_q <= rate_sel;
         if (restart)
            cnt_q <= '0;
         else if (bit_vld && active)
            cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/eic_single_arm.sv
module eic_single_arm
   import eic_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     single_en,
   input  eic_req_t req_i,
   input  logic     bit_vld,
   output logic     req_o,
   output logic     pend_o,
   output logic     fire_o
);

   logic pend_q;

   assign req_o  = single_en & (req_i.sw | req_i.pin);
   assign fire_o = pend_q & bit_vld & single_en;
   assign pend_o = pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (!single_en) pend_q <= 1'b0;
      else if (req_o)      pend_q <= 1'b1;
      else if (fire_o)     pend_q <= 1'b0;
   end

endmodule

// File: rtl/err_inject_ctrl.sv
module err_inject_ctrl
   import eic_pkg::*;
#(
   parameter int MAX_EXP     = 7,
   parameter int SYNC_STAGES = 2,
   parameter int ERR_CNT_W   = 16,
   parameter bit COUNT_EN    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bit_in,
   input  logic                  bit_vld,
   input  logic [EIC_RATE_W-1:0] rate_sel,
   input  logic                  single_en,
   input  logic                  sw_strobe,
   input  logic                  pin_req,
   output logic                  bit_out,
   output logic [ERR_CNT_W-1:0]  err_cnt
);

   if (MAX_EXP < 1 || MAX_EXP > 7) begin : g_bad_exp
      $error("MAX_EXP must lie in 1..7");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ERR_CNT_W < 1) begin : g_bad_cnt
      $error("ERR_CNT_W must be at least 1");
   end

   logic     pin_rise;
   logic     rate_hit;
   logic     single_fire;
   logic     req_w;
   logic     pend_w;
   logic     flip;
   eic_req_t req;

   eic_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_req),
      .rise_o (pin_rise)
   );

   eic_decade_rate #(.MAX_EXP(MAX_EXP)) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_sel (rate_sel),
      .bit_vld  (bit_vld),
      .hit_o    (rate_hit)
   );

   assign req.sw  = sw_strobe;
   assign req.pin = pin_rise;

   eic_single_arm u_arm (
      .clk       (clk),
      .rst_n     (rst_n),
      .single_en (single_en),
      .req_i     (req),
      .bit_vld   (bit_vld),
      .req_o     (req_w),
      .pend_o    (pend_w),
      .fire_o    (single_fire)
   );

   // both sources merge into one inversion
   assign flip    = rate_hit | single_fire;
   assign bit_out = bit_in ^ flip;

   if (COUNT_EN) begin : g_cnt
      logic [ERR_CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                  cnt_q <= '0;
         else if (flip && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      end
      assign err_cnt = cnt_q;
   end else begin : g_no_cnt
      assign err_cnt = '0;
   end

endmodule

// File: rtl/eic_chk.sv
module eic_chk #(
   parameter int ERR_CNT_W = 16,
   parameter bit COUNT_EN  = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bit_in,
   input logic                 bit_vld,
   input logic                 bit_out,
   input logic [2:0]           rate_sel,
   input logic                 single_en,
   input logic                 pend,
   input logic                 req,
   input logic [ERR_CNT_W-1:0] err_cnt
);

   assert_idle_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |-> bit_out == bit_in);

   assert_all_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel == 3'd0 && !single_en) |-> bit_out == bit_in);

   assert_disabled_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !single_en |=> !pend);

   assert_pend_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !bit_vld && single_en) |=> pend);

   assert_pend_consumed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && bit_vld && single_en && !req) |=> !pend);

   assert_pend_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && bit_vld && single_en) |-> bit_out != bit_in);

   assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (COUNT_EN && bit_out != bit_in && err_cnt != '1) |=> err_cnt == $past(err_cnt) + 1'b1);

   assert_cnt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_out == bit_in) |=> $stable(err_cnt));

endmodule

bind err_inject_ctrl eic_chk #(.ERR_CNT_W(ERR_CNT_W), .COUNT_EN(COUNT_EN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_in    (bit_in),
   .bit_vld   (bit_vld),
   .bit_out   (bit_out),
   .rate_sel  (rate_sel),
   .single_en (single_en),
   .pend      (pend_w),
   .req       (req_w),
   .err_cnt   (err_cnt)
);

// File: tb/err_inject_ctrl_tb_top.sv
module err_inject_ctrl_tb_top;

   localparam int CLK_P   = 10;
   localparam int MAX_EXP = 4;
   localparam int SYNC    = 3;
   localparam int CW      = 6;
   localparam int CMAX    = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_in = 1'b0;
   logic          bit_vld = 1'b0;
   logic [2:0]    rate_sel = 3'd0;
   logic          single_en = 1'b0;
   logic          sw_strobe = 1'b0;
   logic          pin_req = 1'b0;
   logic          bit_out;
   logic [CW-1:0] err_cnt;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   err_inject_ctrl #(.MAX_EXP(MAX_EXP), .SYNC_STAGES(SYNC), .ERR_CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
      .rate_sel(rate_sel), .single_en(single_en), .sw_strobe(sw_strobe),
      .pin_req(pin_req), .bit_out(bit_out), .err_cnt(err_cnt));

   typedef struct {
      logic  eb;
      int    ec;
      string tag;
   } exp_t;
   exp_t sb_q[$];

   // next-cycle control values, applied by the driver
   logic [2:0] nx_rate = 3'd0;
   logic       nx_se = 1'b0;
   logic       nx_sw = 1'b0;
   logic       nx_pin = 1'b0;

   // reference model state
   int   m_rq = 0;
   int   m_cnt = 0;
   bit   m_pend = 1'b0;
   bit   m_sync [SYNC];
   bit   m_prev = 1'b0;
   int   m_err = 0;

   function automatic int lim_of(input int v);
      int e = (v > MAX_EXP) ? MAX_EXP : v;
      int p = 1;
      for (int i = 0; i < e; i++) p = p * 10;
      return p - 1;
   endfunction

   task automatic drive_bit(input logic b, input logic v, input string tag);
      bit   hit, fire, flip, rise, req;
      exp_t it;
      @(negedge clk);
      bit_in = b; bit_vld = v; rate_sel = nx_rate; single_en = nx_se;
      sw_strobe = nx_sw; pin_req = nx_pin;
      nx_sw = 1'b0;
      hit  = v && (int'(nx_rate) == m_rq) && (m_rq != 0) && (m_cnt == lim_of(m_rq));
      fire = m_pend && v && nx_se;
      flip = hit || fire;
      it.eb = b ^ flip; it.ec = m_err; it.tag = tag;
      sb_q.push_back(it);
      rise = m_sync[SYNC-1] && !m_prev;
      req  = nx_se && (nx_sw_prev_get() || rise);
      m_prev = m_sync[SYNC-1];
      for (int i = SYNC-1; i > 0; i--) m_sync[i] = m_sync[i-1];
      m_sync[0] = nx_pin;
      if (!nx_se)   m_pend = 1'b0;
      else if (req) m_pend = 1'b1;
      else if (fire) m_pend = 1'b0;
      if (int'(nx_rate) != m_rq) begin
         m_cnt = 0; m_rq = int'(nx_rate);
      end else if (v && m_rq != 0) begin
         m_cnt = (m_cnt == lim_of(m_rq)) ? 0 : m_cnt + 1;
      end
      if (flip && m_err < CMAX) m_err++;
   endtask

   function automatic bit nx_sw_prev_get();
      return sw_strobe;
   endfunction

   task automatic run_bits(input int n, input int vld_pct, input string tag);
      for (int i = 0; i < n; i++)
         drive_bit(1'($urandom), (($urandom % 100) < vld_pct), tag);
   endtask

   // monitor: compare outputs against the scoreboard
   always @(negedge clk) begin
      #2;
      if (sb_q.size() > 0) begin
         exp_t it;
         it = sb_q.pop_front();
         n_run++;
         if (bit_out !== it.eb) begin
            n_fail++;
            $display("FAIL %s bit_out=%b expected %b at %0t", it.tag, bit_out, it.eb, $time);
         end
         n_run++;
         if (int'(err_cnt) != it.ec) begin
            n_fail++;
            $display("FAIL R10 err_cnt=%0d expected %0d at %0t (%s)", err_cnt, it.ec, $time, it.tag);
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog expired, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < SYNC; i++) m_sync[i] = 1'b0;
      // R1: reset state
      bit_in = 1'b1; bit_vld = 1'b1; rate_sel = 3'd1; single_en = 1'b1;
      repeat (5) @(negedge clk);
      #2;
      n_run++;
      if (bit_out !== 1'b1) begin
         n_fail++; $display("FAIL R1 bit_out=%b expected 1 in reset", bit_out);
      end
      n_run++;
      if (err_cnt !== '0) begin
         n_fail++; $display("FAIL R1 err_cnt=%0d expected 0 in reset", err_cnt);
      end
      bit_vld = 1'b0; rate_sel = 3'd0; single_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      drive_bit(1'b0, 1'b1, "R1");
      drive_bit(1'b1, 1'b1, "R1");

      // R2: rate off, single mode off
      nx_rate = 3'd0; nx_se = 1'b0;
      run_bits(40, 100, "R2");

      // R3: n = 1 and n = 2, continuous strobes
      nx_rate = 3'd1; run_bits(60, 100, "R3");
      nx_rate = 3'd2; run_bits(250, 100, "R3");

      // R4: gapped strobes at n = 1
      nx_rate = 3'd0; drive_bit(1'b0, 1'b1, "R4");
      nx_rate = 3'd1; run_bits(120, 50, "R4");

      // R3: n = 3, then field 6 clamped to MAX_EXP
      nx_rate = 3'd3; run_bits(2100, 100, "R3");
      nx_rate = 3'd6; run_bits(10005, 100, "R3");

      // R5: restart on change, strobed bit in change cycle
      nx_rate = 3'd2; run_bits(57, 100, "R5");
      nx_rate = 3'd1; run_bits(25, 100, "R5");
      nx_rate = 3'd2; run_bits(30, 100, "R5");

      // R6: software single error
      nx_rate = 3'd0; nx_se = 1'b1;
      run_bits(3, 100, "R6");
      nx_sw = 1'b1; run_bits(20, 100, "R6");

      // R11: pending across idle cycles, merged requests
      nx_sw = 1'b1; drive_bit(1'b0, 1'b0, "R11");
      nx_sw = 1'b1; drive_bit(1'b1, 1'b0, "R11");
      run_bits(8, 0, "R11");
      run_bits(15, 100, "R11");

      // R7: pin held high for many cycles, then a second pulse
      nx_pin = 1'b1; run_bits(30, 100, "R7");
      nx_pin = 1'b0; run_bits(20, 100, "R7");
      nx_pin = 1'b1; run_bits(2, 100, "R7");
      nx_pin = 1'b0; run_bits(20, 60, "R7");

      // R8: requests ignored while disabled, pending dropped
      nx_se = 1'b0;
      nx_sw = 1'b1; run_bits(5, 100, "R8");
      nx_pin = 1'b1; run_bits(10, 100, "R8");
      nx_pin = 1'b0; run_bits(10, 100, "R8");
      nx_se = 1'b1; nx_sw = 1'b1; drive_bit(1'b0, 1'b0, "R8");
      run_bits(3, 0, "R8");
      nx_se = 1'b0; run_bits(15, 100, "R8");

      // R9: rate hit coinciding with pending single error
      nx_se = 1'b1; nx_rate = 3'd0; drive_bit(1'b0, 1'b0, "R9");
      nx_rate = 3'd1; drive_bit(1'b0, 1'b0, "R9");
      run_bits(8, 100, "R9");
      nx_sw = 1'b1; drive_bit(1'b1, 1'b1, "R9");
      run_bits(15, 100, "R9");
      nx_se = 1'b0;

      // R10: saturation of the error counter
      run_bits(700, 100, "R10");

      nx_rate = 3'd0;
      run_bits(4, 0, "R10");
      repeat (3) @(negedge clk);
      #5;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule